// File: doc/BRIEF.md
# Two-Level Segment and Page Address Translator

The block turns a 24-bit virtual address into a real address in two dependent steps. The top bits of the address pick an entry in a segment table. The segment table sits in memory at an address held in a base register. That entry names the page table for the segment. The middle bits then pick an entry in that page table, and the entry gives a frame number. The frame number, placed above the unchanged byte offset, is the real address. Both table reads go out through one word-wide memory read port with a request/grant handshake followed by a data-valid strobe.

A client offers a virtual address with `req_valid` and sees it taken on a clock edge where `req_ready` is high. Some cycles later, `rsp_valid` pulses for one cycle and carries the real address and a two-bit fault code. A missing segment, a page number past the segment's limit or a missing page ends the walk early with a fault. A new request may be taken in the same cycle that the previous result is delivered. This lets translations follow one another with no idle cycle between them.

Top module: `seg_page_xlate`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `rsp_valid` and `mem_req_valid` are 0 and `req_ready` is 1.
- R2: The first memory read of a translation goes to byte address `seg_base + 4*vaddr[23:20]` (modulo 2^22).
- R3: A segment entry with bit 31 clear ends the translation with fault code 1 and a zero address. Exactly one memory read is made.
- R4: A valid segment entry whose limit field (bits 30:23) is below the page number `vaddr[19:12]` ends the translation with fault code 3 after exactly one memory read. A page number equal to the limit is allowed.
- R5: For a valid, in-limit segment entry, the second read goes to `entry[21:0] + 4*vaddr[19:12]` (modulo 2^22).
- R6: A page entry with bit 31 clear ends the translation with fault code 2 and a zero address, after exactly two memory reads.
- R7: A valid page entry gives fault code 0 and `rsp_paddr = {entry[11:0], vaddr[11:0]}`.
- R8: Once raised, `mem_req_valid` stays high with an unchanged `mem_req_addr` until a cycle with `mem_req_ready` high.
- R9: `req_ready` is high only when no walk is in progress, which includes the result cycle. A request taken in the result cycle puts out its segment read in the very next cycle.
- R10: `req_vaddr` and `seg_base` are sampled only when a request is taken. Later changes to them do not affect that translation's reads or result.
- R11: `rsp_valid` lasts exactly one cycle per translation, and `rsp_paddr` is zero whenever `rsp_fault` is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seg_base | input | 22 | Byte address of the segment table |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Request is taken on this edge when valid |
| req_vaddr | input | 24 | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_paddr | output | 24 | Real address (zero on fault) |
| rsp_fault | output | 2 | 0 ok, 1 segment missing, 2 page missing, 3 page past limit |
| mem_req_valid | output | 1 | Table read requested |
| mem_req_ready | input | 1 | Memory takes the read on this edge |
| mem_req_addr | output | 22 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Table entry word |

## Verification
The result of one translation and the acceptance of the next can fall on the same edge. In that cycle the block both presents `rsp_valid` and raises `req_ready`. The bench provokes this by offering a second address while the first walk is still running, so the request waits until the result cycle. The cycle model then expects the result and the new segment read on consecutive cycles. A count of memory grants per translation confirms that the old walk's data never leaks into the new one. The grant and data delays of the memory stub are varied so that the overlap is met after both short and long walks.

// File: rtl/xlate_pkg.sv
// Shared types for the two-level translator.
// Assumes 32-bit table entries with the valid flag in the top bit.
package xlate_pkg;

    localparam int ENTRY_W      = 32;
    localparam int VALID_BIT    = 31;
    localparam int ENTRY_SHIFT  = 2;   // entries are four bytes apart

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_SEG_REQ  = 3'd1,
        ST_SEG_WAIT = 3'd2,
        ST_PG_REQ   = 3'd3,
        ST_PG_WAIT  = 3'd4,
        ST_RESP     = 3'd5
    } walk_state_t;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_SEG   = 2'd1,
        FLT_PAGE  = 2'd2,
        FLT_LIMIT = 2'd3
    } walk_fault_t;

endpackage

// File: rtl/xlate_field_split.sv
// Splits a virtual address into segment, page and byte-offset fields.
// Assumes the fields are packed high to low with no gaps.
module xlate_field_split #(
    parameter int SEG_W = 4,
    parameter int PG_W  = 8,
    parameter int OFF_W = 12,
    localparam int VA_W = SEG_W + PG_W + OFF_W
) (
    input  logic [VA_W-1:0]  vaddr,
    output logic [SEG_W-1:0] seg_idx,
    output logic [PG_W-1:0]  pg_idx,
    output logic [OFF_W-1:0] byte_off
);
    // Pure field slicing.
    always_comb begin
        seg_idx  = vaddr[VA_W-1 -: SEG_W];
        pg_idx   = vaddr[OFF_W +: PG_W];
        byte_off = vaddr[OFF_W-1:0];
    end
endmodule

// File: rtl/xlate_entry_addr.sv
// Forms the byte address of a table entry from a table base and an index.
// Assumes fixed-size entries; the sum wraps at the address width.
module xlate_entry_addr #(
    parameter int MA_W  = 22,
    parameter int IDX_W = 4
) (
    input  logic [MA_W-1:0]  tbl_base,
    input  logic [IDX_W-1:0] idx,
    output logic [MA_W-1:0]  ent_addr
);
    import xlate_pkg::*;

    localparam int EXT_W = (IDX_W + ENTRY_SHIFT > MA_W) ? IDX_W + ENTRY_SHIFT : MA_W;

    logic [EXT_W-1:0] scaled;
    logic [EXT_W-1:0] total;

    // Scale the index to a byte offset and add the base.
    always_comb begin
        scaled   = EXT_W'(idx) << ENTRY_SHIFT;
        total    = EXT_W'(tbl_base) + scaled;
        ent_addr = total[MA_W-1:0];
    end
endmodule

// File: rtl/xlate_entry_decode.sv
// Unpacks a table entry word into its valid flag, page limit, table base
// and frame number. The same word is read both as a segment entry and as a
// page entry; the sequencer chooses which fields apply.
module xlate_entry_decode #(
    parameter int MA_W    = 22,
    parameter int PG_W    = 8,
    parameter int FRAME_W = 12
) (
    input  logic [31:0]        word,
    output logic               ent_valid,
    output logic [PG_W-1:0]    pg_limit,
    output logic [MA_W-1:0]    pt_base,
    output logic [FRAME_W-1:0] frame
);
    import xlate_pkg::*;

    // Field extraction; the limit sits just below the valid flag.
    always_comb begin
        ent_valid = word[VALID_BIT];
        pg_limit  = word[VALID_BIT-1 -: PG_W];
        pt_base   = word[MA_W-1:0];
        frame     = word[FRAME_W-1:0];
    end
endmodule

// File: rtl/xlate_walk_fsm.sv
// Sequencer for the two-read table walk. It captures the request, issues
// the segment read, checks the segment entry, issues the page read and
// builds the result. Assumes read data comes no earlier than one cycle after
// the grant, and that only one read is outstanding at a time.
module xlate_walk_fsm #(
    parameter int SEG_W   = 4,
    parameter int PG_W    = 8,
    parameter int OFF_W   = 12,
    parameter int MA_W    = 22,
    parameter int FRAME_W = 12,
    localparam int VA_W   = SEG_W + PG_W + OFF_W,
    localparam int PA_W   = FRAME_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [MA_W-1:0]    seg_base,
    output logic               req_ready,
    output logic [VA_W-1:0]    va_q,
    output logic [MA_W-1:0]    st_base_q,
    output logic [MA_W-1:0]    pt_base_q,
    input  logic [PG_W-1:0]    pg_idx,
    input  logic [OFF_W-1:0]   byte_off,
    input  logic               mem_req_ready,
    input  logic               mem_rsp_valid,
    input  logic               ent_valid,
    input  logic [PG_W-1:0]    pg_limit,
    input  logic [MA_W-1:0]    ent_base,
    input  logic [FRAME_W-1:0] ent_frame,
    output logic               rd_active,
    output logic               rd_is_seg,
    output logic               rsp_valid,
    output logic [PA_W-1:0]    rsp_paddr,
    output logic [1:0]         rsp_fault
);
    import xlate_pkg::*;

    walk_state_t state;
    walk_fault_t fault_q;
    logic        take;

    // Acceptance happens when idle or in the result cycle.
    always_comb begin
        req_ready = (state == ST_IDLE) || (state == ST_RESP);
        take      = req_ready && req_valid;
        rd_active = (state == ST_SEG_REQ) || (state == ST_PG_REQ);
        rd_is_seg = (state == ST_SEG_REQ);
        rsp_valid = (state == ST_RESP);
        rsp_fault = fault_q;
    end

    // Walk state and captured operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            va_q      <= '0;
            st_base_q <= '0;
            pt_base_q <= '0;
            fault_q   <= FLT_NONE;
            rsp_paddr <= '0;
        end else begin
            case (state)
                ST_IDLE, ST_RESP: begin
                    if (take) begin
                        va_q      <= req_vaddr;
                        st_base_q <= seg_base;
                        state     <= ST_SEG_REQ;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_SEG_REQ: begin
                    if (mem_req_ready) state <= ST_SEG_WAIT;
                end
                ST_SEG_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (!ent_valid) begin
                            fault_q   <= FLT_SEG;
                            rsp_paddr <= '0;
                            state     <= ST_RESP;
                        end else if (pg_idx > pg_limit) begin
                            fault_q   <= FLT_LIMIT;
                            rsp_paddr <= '0;
                            state     <= ST_RESP;
                        end else begin
                            pt_base_q <= ent_base;
                            state     <= ST_PG_REQ;
                        end
                    end
                end
                ST_PG_REQ: begin
                    if (mem_req_ready) state <= ST_PG_WAIT;
                end
                ST_PG_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (!ent_valid) begin
                            fault_q   <= FLT_PAGE;
                            rsp_paddr <= '0;
                        end else begin
                            fault_q   <= FLT_NONE;
                            rsp_paddr <= {ent_frame, byte_off};
                        end
                        state <= ST_RESP;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/seg_page_xlate.sv
// Top of the two-level translator. Joins the field splitter, the two
// entry-address adders, the entry decoder and the walk sequencer, and
// steers the shared memory read port. Assumes a single outstanding read.
module seg_page_xlate #(
    parameter int SEG_W   = 4,
    parameter int PG_W    = 8,
    parameter int OFF_W   = 12,
    parameter int MA_W    = 22,
    parameter int FRAME_W = 12,
    localparam int VA_W   = SEG_W + PG_W + OFF_W,
    localparam int PA_W   = FRAME_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MA_W-1:0]    seg_base,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    output logic               rsp_valid,
    output logic [PA_W-1:0]    rsp_paddr,
    output logic [1:0]         rsp_fault,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [MA_W-1:0]    mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [31:0]        mem_rsp_data
);
    logic [VA_W-1:0]    va_q;
    logic [MA_W-1:0]    st_base_q;
    logic [MA_W-1:0]    pt_base_q;
    logic [SEG_W-1:0]   seg_idx;
    logic [PG_W-1:0]    pg_idx;
    logic [OFF_W-1:0]   byte_off;
    logic [MA_W-1:0]    seg_ent_addr;
    logic [MA_W-1:0]    pg_ent_addr;
    logic               ent_valid;
    logic [PG_W-1:0]    pg_limit;
    logic [MA_W-1:0]    ent_base;
    logic [FRAME_W-1:0] ent_frame;
    logic               rd_active;
    logic               rd_is_seg;

    xlate_field_split #(.SEG_W(SEG_W), .PG_W(PG_W), .OFF_W(OFF_W)) u_split (
        .vaddr    (va_q),
        .seg_idx  (seg_idx),
        .pg_idx   (pg_idx),
        .byte_off (byte_off)
    );

    xlate_entry_addr #(.MA_W(MA_W), .IDX_W(SEG_W)) u_seg_addr (
        .tbl_base (st_base_q),
        .idx      (seg_idx),
        .ent_addr (seg_ent_addr)
    );

    xlate_entry_addr #(.MA_W(MA_W), .IDX_W(PG_W)) u_pg_addr (
        .tbl_base (pt_base_q),
        .idx      (pg_idx),
        .ent_addr (pg_ent_addr)
    );

    xlate_entry_decode #(.MA_W(MA_W), .PG_W(PG_W), .FRAME_W(FRAME_W)) u_dec (
        .word      (mem_rsp_data),
        .ent_valid (ent_valid),
        .pg_limit  (pg_limit),
        .pt_base   (ent_base),
        .frame     (ent_frame)
    );

    xlate_walk_fsm #(
        .SEG_W(SEG_W), .PG_W(PG_W), .OFF_W(OFF_W), .MA_W(MA_W), .FRAME_W(FRAME_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_vaddr     (req_vaddr),
        .seg_base      (seg_base),
        .req_ready     (req_ready),
        .va_q          (va_q),
        .st_base_q     (st_base_q),
        .pt_base_q     (pt_base_q),
        .pg_idx        (pg_idx),
        .byte_off      (byte_off),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .ent_valid     (ent_valid),
        .pg_limit      (pg_limit),
        .ent_base      (ent_base),
        .ent_frame     (ent_frame),
        .rd_active     (rd_active),
        .rd_is_seg     (rd_is_seg),
        .rsp_valid     (rsp_valid),
        .rsp_paddr     (rsp_paddr),
        .rsp_fault     (rsp_fault)
    );

    // Steer the shared read port to whichever table is being read.
    always_comb begin
        mem_req_valid = rd_active;
        mem_req_addr  = rd_is_seg ? seg_ent_addr : pg_ent_addr;
    end
endmodule

// File: rtl/xlate_chk.sv
// Port-level protocol checks for the translator, attached by bind.
module xlate_chk #(
    parameter int MA_W = 22,
    parameter int PA_W = 24
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            rsp_valid,
    input logic [PA_W-1:0] rsp_paddr,
    input logic [1:0]      rsp_fault,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [MA_W-1:0] mem_req_addr
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!rsp_valid && !mem_req_valid && req_ready));

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R9
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    // R9
    chain_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && req_valid && req_ready) |=> mem_req_valid);

    // R11
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R11
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == '0));
endmodule

bind seg_page_xlate xlate_chk #(.MA_W(MA_W), .PA_W(PA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .rsp_paddr     (rsp_paddr),
    .rsp_fault     (rsp_fault),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr)
);

// File: tb/sim_seg_page_xlate.sv
module sim_seg_page_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [21:0] seg_base = 22'h1000;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_vaddr = '0;
    logic        rsp_valid;
    logic [23:0] rsp_paddr;
    logic [1:0]  rsp_fault;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [21:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    always #5 clk = ~clk;

    seg_page_xlate u0 (.*);

    int checks = 0, fails = 0, cyc = 0;
    logic [31:0] mem [int];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [21:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : 32'h0;
    endfunction

    // Expected result from the requirements: {grants, fault, paddr}
    function automatic logic [27:0] calc(input logic [23:0] va, input logic [21:0] base);
        logic [31:0] se, pe;
        logic [21:0] a;
        a  = base + 22'(va[23:20]) * 22'd4;
        se = rd(a);
        if (!se[31]) return {2'd1, 2'd1, 24'h0};
        if (va[19:12] > se[30:23]) return {2'd1, 2'd3, 24'h0};
        a  = se[21:0] + 22'(va[19:12]) * 22'd4;
        pe = rd(a);
        if (!pe[31]) return {2'd2, 2'd2, 24'h0};
        return {2'd2, 2'd0, pe[11:0], va[11:0]};
    endfunction

    // Memory stub with adjustable grant and data delays
    int gnt_knob = 0, rsp_knob = 0, gnt_cnt = 0, rsp_cnt = 0, grants = 0;
    bit pend = 0;
    logic [21:0] pend_addr;
    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        mem_req_ready = 1'b0;
        if (pend) begin
            if (rsp_cnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = rd(pend_addr);
                pend = 0;
            end else rsp_cnt--;
        end else if (mem_req_valid && rst_n) begin
            if (gnt_cnt == 0) begin
                mem_req_ready = 1'b1;
                pend = 1;
                pend_addr = mem_req_addr;
                rsp_cnt = rsp_knob;
                gnt_cnt = gnt_knob;
                grants++;
            end else gnt_cnt--;
        end
    end

    // Cycle reference model, advanced on each edge from the inputs
    int m_ph = 0;
    logic [23:0] m_va;
    logic [21:0] m_base, m_pt;
    logic [1:0]  m_flt = 0;
    logic [23:0] m_pa = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_flt = 0; m_pa = 0;
        end else begin
            case (m_ph)
                0, 5: if (req_valid) begin m_va = req_vaddr; m_base = seg_base; m_ph = 1; end
                      else m_ph = 0;
                1: if (mem_req_ready) m_ph = 2;
                2: if (mem_rsp_valid) begin
                       if (!mem_rsp_data[31]) begin m_flt = 1; m_pa = 0; m_ph = 5; end
                       else if (m_va[19:12] > mem_rsp_data[30:23]) begin m_flt = 3; m_pa = 0; m_ph = 5; end
                       else begin m_pt = mem_rsp_data[21:0]; m_ph = 3; end
                   end
                3: if (mem_req_ready) m_ph = 4;
                4: if (mem_rsp_valid) begin
                       if (!mem_rsp_data[31]) begin m_flt = 2; m_pa = 0; end
                       else begin m_flt = 0; m_pa = {mem_rsp_data[11:0], m_va[11:0]}; end
                       m_ph = 5;
                   end
                default: m_ph = 0;
            endcase
        end
    end

    // Compare against the model every cycle
    always @(negedge clk) begin
        if (rst_n) begin
            chk(req_ready == (m_ph == 0 || m_ph == 5), "R9 req_ready", 32'(req_ready), 32'(m_ph));
            chk(mem_req_valid == (m_ph == 1 || m_ph == 3), "R8 mem_req_valid", 32'(mem_req_valid), 32'(m_ph));
            if (m_ph == 1)
                chk(mem_req_addr == 22'(m_base + 22'(m_va[23:20]) * 22'd4), "R2 seg read addr",
                    32'(mem_req_addr), 32'(22'(m_base + 22'(m_va[23:20]) * 22'd4)));
            if (m_ph == 3)
                chk(mem_req_addr == 22'(m_pt + 22'(m_va[19:12]) * 22'd4), "R5 page read addr",
                    32'(mem_req_addr), 32'(22'(m_pt + 22'(m_va[19:12]) * 22'd4)));
            chk(rsp_valid == (m_ph == 5), "R11 rsp_valid", 32'(rsp_valid), 32'(m_ph));
            if (m_ph == 5) begin
                chk(rsp_fault == m_flt, "R7 model fault", 32'(rsp_fault), 32'(m_flt));
                chk(rsp_paddr == m_pa, "R7 model paddr", 32'(rsp_paddr), 32'(m_pa));
            end
        end
    end

    // Result check against values computed from table contents
    logic [27:0] exp_q[$];
    int n_rsp = 0;
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            logic [27:0] e;
            string tag;
            n_rsp++;
            if (exp_q.size() == 0) chk(0, "R11 unexpected rsp", 0, 0);
            else begin
                e = exp_q.pop_front();
                case (e[25:24])
                    2'd1: tag = "R3 segment fault";
                    2'd2: tag = "R6 page fault";
                    2'd3: tag = "R4 limit fault";
                    default: tag = "R7 translation";
                endcase
                chk(rsp_fault == e[25:24], {tag, " code"}, 32'(rsp_fault), 32'(e[25:24]));
                chk(rsp_paddr == e[23:0], {tag, " paddr"}, 32'(rsp_paddr), 32'(e[23:0]));
                chk(grants == int'(e[27:26]), {tag, " read count"}, 32'(grants), 32'(e[27:26]));
            end
        end
    end

    int chained = 0;
    // Offer one address and return just after it has been taken
    task automatic send(input logic [23:0] va);
        bit was_rsp;
        req_valid = 1'b1;
        req_vaddr = va;
        while (!req_ready) @(negedge clk);
        was_rsp = rsp_valid;
        @(posedge clk);
        exp_q.push_back(calc(va, seg_base));
        grants = 0;
        @(negedge clk);
        req_valid = 1'b0;
        if (was_rsp) begin
            chained++;
            chk(mem_req_valid == 1'b1, "R9 chained segment read", 32'(mem_req_valid), 1);
        end
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    localparam logic [23:0] VAS [9] = '{24'h002100, 24'h100000, 24'h203FFF, 24'h204000,
                                        24'h305010, 24'h306020, 24'hFFFABC, 24'h000000, 24'h0FF001};

    initial begin
        // tables: segment table at 0x1000, spare empty table at 0x5000
        mem[32'h1000] = 32'h8000_0000 | (32'hFF << 23) | 32'h2000;  // seg 0
        mem[32'h1008] = 32'h8000_0000 | (32'h03 << 23) | 32'h3000;  // seg 2, limit 3
        mem[32'h100C] = 32'h8000_0000 | (32'hFF << 23) | 32'h4000;  // seg 3
        mem[32'h103C] = 32'h8000_0000 | (32'hFF << 23) | 32'h3FF000;// seg 15
        mem[32'h2000] = 32'h8000_0001;
        mem[32'h2008] = 32'h8000_0ABC;
        mem[32'h23FC] = 32'h8000_0FFF;
        mem[32'h3000] = 32'h8000_0300;
        mem[32'h300C] = 32'h8000_0333;
        mem[32'h4014] = 32'h0000_0ABC;                               // page 5 missing
        mem[32'h4018] = 32'h8000_0456;
        mem[32'h3FF3FC] = 32'h8000_00F0;

        repeat (3) @(negedge clk);
        chk(!rsp_valid && !mem_req_valid && req_ready, "R1 reset outputs",
            {29'h0, rsp_valid, mem_req_valid, req_ready}, 32'h1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rsp_valid && !mem_req_valid && req_ready, "R1 after reset",
            {29'h0, rsp_valid, mem_req_valid, req_ready}, 32'h1);

        // single walks with several memory delays (R2 R3 R4 R5 R6 R7)
        for (int d = 0; d < 3; d++) begin
            gnt_knob = d; rsp_knob = 2 - d;
            foreach (VAS[i]) begin send(VAS[i]); drain(); end
        end

        // back-to-back requests taken in the result cycle (R9)
        for (int d = 0; d < 3; d++) begin
            gnt_knob = d % 2; rsp_knob = d;
            foreach (VAS[i]) send(VAS[i]);
            drain();
        end
        chk(chained >= 20, "R9 overlap count", 32'(chained), 20);

        // inputs changed after acceptance must not matter (R10)
        gnt_knob = 1; rsp_knob = 1;
        send(24'h002100);
        seg_base = 22'h5000; req_vaddr = 24'h100000;
        drain();
        seg_base = 22'h1000;
        send(24'h306020);
        seg_base = 22'h5000;
        drain();
        seg_base = 22'h1000;
        chk(n_rsp == 56, "R11 response count", 32'(n_rsp), 56);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 50000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule